// File: doc/BRIEF.md
# Multimode Timer Channel

This block is one timer channel that can be switched at run time between three uses of the same counter hardware. As two independent 8-bit pulse-width generators, the 16-bit count splits into a low half and a high half, each with its own period and duty byte and its own output. As one wide pulse-width generator, the halves join into a single 16-bit counter. As a timebase for measurement, the counter runs freely and two capture channels record its value when an external pin shows a chosen edge.

An 8-bit divider ahead of the counter sets the count rate. A small write/read register interface holds the configuration. Period and duty values are double-buffered, so a change only takes effect at a period boundary. A system that needs several such channels instantiates copies side by side, each with its own configuration.

Register addresses (16-bit data): 0 configuration, 1 divider, 2 period, 3 duty, 4 capture value 0, 5 capture value 1, 6 capture flags, 7 current count.

Top module: `mmt_channel`

## Requirements
- R1: Writes to addresses 0 to 3 update the configuration, divider (bits 7:0), period and duty registers, and reads at those addresses return them. After reset the configuration, divider, period, duty, flags and count all read 0.
- R2: A divider value N advances the counter once every N+1 clocks.
- R3: Configuration bits 1:0 select the mode: 0 is dual 8-bit PWM, 1 is 16-bit PWM, 2 or 3 is capture. In dual mode the low count byte uses period bits 7:0 and duty bits 7:0 and drives pwm_out[0], while the high count byte uses bits 15:8 and drives pwm_out[1].
- R4: A PWM output is high while its count is below its duty value, and the count returns to 0 on the advance after it equals the period. For period P, duty D and divider N, the output is high for min(D,P+1)*(N+1) of every (P+1)*(N+1) clocks.
- R5: In 16-bit PWM mode pwm_out[0] carries the waveform and pwm_out[1] stays low.
- R6: In capture mode the 16-bit counter runs freely and wraps from 0xFFFF to 0, and both PWM outputs are low.
- R7: Each capture input passes through a two-stage synchronizer. With divider 0, a pin change applied before clock edge k+1 stores the count held after edge k+2.
- R8: Configuration bit 2 selects the capture edge of channel 0 and bit 3 that of channel 1 (0 rising, 1 falling). The other edge is ignored.
- R9: A capture sets that channel's sticky flag (address 6, bit 0 channel 0, bit 1 channel 1). Writing 1 to a flag bit clears it. cap_irq is high while any flag is set.
- R10: Pin edges outside capture mode store nothing and set no flag.
- R11: A write that changes the mode clears the counter and the divider. After the write edge the count reads 0 and the first advance comes N+1 clocks later.
- R12: New period and duty values take effect only when the running period ends, or on a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cap_in | input | 2 | Asynchronous capture pins |
| pwm_out | output | 2 | PWM outputs |
| cap_irq | output | 1 | Capture interrupt, high while any flag is set |

## Verification
On every cycle, the embedded properties check the following:
- the spacing of divider ticks;
- that the 16-bit count stays within its active period;
- that a mode change leaves the count at zero;
- that the buffered duty holds steady inside a period;
- that a capture stores the count of the cycle before;
- that flags stay set until written, and never rise outside capture mode.

Only the bench scenarios can show the following:
- the duty ratios over whole periods, for swept period, duty and divider settings in both PWM modes;
- the exact capture value after synchronizer delay with two divider settings;
- rejection of the unselected edge;
- the 16-bit wrap;
- the timing of a duty change written in the middle of a period.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL8 = 2'd0,
        MODE_WIDE  = 2'd1,
        MODE_CAPT  = 2'd2,
        MODE_CAPTX = 2'd3
    } mode_e;

    localparam int unsigned REG_AW  = 3;
    localparam int unsigned NUM_CAP = 2;

    localparam logic [REG_AW-1:0] A_CFG  = 3'd0;
    localparam logic [REG_AW-1:0] A_PRE  = 3'd1;
    localparam logic [REG_AW-1:0] A_PER  = 3'd2;
    localparam logic [REG_AW-1:0] A_DUTY = 3'd3;
    localparam logic [REG_AW-1:0] A_CAP0 = 3'd4;
    localparam logic [REG_AW-1:0] A_CAP1 = 3'd5;
    localparam logic [REG_AW-1:0] A_FLAG = 3'd6;
    localparam logic [REG_AW-1:0] A_CNT  = 3'd7;

    function automatic logic is_capt(mode_e m);
        return (m == MODE_CAPT) || (m == MODE_CAPTX);
    endfunction

endpackage

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_s;

    pre_s pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        tick  = (pre_q.cnt >= limit) && !clear;
        if (clear || tick) pre_d.cnt = '0;
        else               pre_d.cnt = pre_q.cnt + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2: after a tick the next tick is one clock away only for a zero limit
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || limit == '0));

endmodule

// File: rtl/mmt_counter.sv
module mmt_counter
    import mmt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  mode_e            mode,
    input  logic [CNT_W-1:0] per_cfg,
    input  logic [CNT_W-1:0] duty_cfg,
    output logic [CNT_W-1:0] count,
    output logic [1:0]       pwm
);
    localparam int unsigned HALF_W = CNT_W / 2;

    typedef struct packed {
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] hi;
        logic [CNT_W-1:0]  act_per;
        logic [CNT_W-1:0]  act_duty;
    } cnt_s;

    cnt_s cnt_d, cnt_q;
    logic lo_top, hi_top, full_top;

    always_comb begin
        cnt_d    = cnt_q;
        lo_top   = (cnt_q.lo == cnt_q.act_per[HALF_W-1:0]);
        hi_top   = (cnt_q.hi == cnt_q.act_per[CNT_W-1:HALF_W]);
        full_top = ({cnt_q.hi, cnt_q.lo} == cnt_q.act_per);
        if (clear) begin
            cnt_d.lo       = '0;
            cnt_d.hi       = '0;
            cnt_d.act_per  = per_cfg;
            cnt_d.act_duty = duty_cfg;
        end else if (tick) begin
            unique case (mode)
                MODE_DUAL8: begin
                    if (lo_top) begin
                        cnt_d.lo = '0;
                        cnt_d.act_per[HALF_W-1:0]  = per_cfg[HALF_W-1:0];
                        cnt_d.act_duty[HALF_W-1:0] = duty_cfg[HALF_W-1:0];
                    end else begin
                        cnt_d.lo = cnt_q.lo + HALF_W'(1);
                    end
                    if (hi_top) begin
                        cnt_d.hi = '0;
                        cnt_d.act_per[CNT_W-1:HALF_W]  = per_cfg[CNT_W-1:HALF_W];
                        cnt_d.act_duty[CNT_W-1:HALF_W] = duty_cfg[CNT_W-1:HALF_W];
                    end else begin
                        cnt_d.hi = cnt_q.hi + HALF_W'(1);
                    end
                end
                MODE_WIDE: begin
                    if (full_top) begin
                        {cnt_d.hi, cnt_d.lo} = '0;
                        cnt_d.act_per  = per_cfg;
                        cnt_d.act_duty = duty_cfg;
                    end else begin
                        {cnt_d.hi, cnt_d.lo} = {cnt_q.hi, cnt_q.lo} + CNT_W'(1);
                    end
                end
                default: {cnt_d.hi, cnt_d.lo} = {cnt_q.hi, cnt_q.lo} + CNT_W'(1);
            endcase
        end
    end

    always_comb begin
        count = {cnt_q.hi, cnt_q.lo};
        pwm   = 2'b00;
        if (mode == MODE_DUAL8) begin
            pwm[0] = cnt_q.lo < cnt_q.act_duty[HALF_W-1:0];
            pwm[1] = cnt_q.hi < cnt_q.act_duty[CNT_W-1:HALF_W];
        end else if (mode == MODE_WIDE) begin
            pwm[0] = count < cnt_q.act_duty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_mode_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));

    assert_wide_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WIDE) |-> (count <= cnt_q.act_per));

    assert_duty_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WIDE && !clear && !(tick && full_top)) |=> $stable(cnt_q.act_duty));

endmodule

// File: rtl/mmt_capture.sv
module mmt_capture #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             fall_sel,
    input  logic             enable,
    input  logic [CNT_W-1:0] count,
    output logic             hit,
    output logic [CNT_W-1:0] value
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              prev;
        logic [CNT_W-1:0]  value;
    } cap_s;

    cap_s cap_d, cap_q;
    logic now_lvl;

    always_comb begin
        cap_d      = cap_q;
        now_lvl    = cap_q.sync[SYNC_N-1];
        cap_d.sync = {cap_q.sync[SYNC_N-2:0], pin};
        cap_d.prev = now_lvl;
        hit = enable && (fall_sel ? (cap_q.prev && !now_lvl) : (!cap_q.prev && now_lvl));
        if (hit) cap_d.value = count;
        value = cap_q.value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assert_cap_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (value == $past(count)));

endmodule

// File: rtl/mmt_channel.sv
module mmt_channel
    import mmt_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PRE_W  = 8,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic [NUM_CAP-1:0] cap_in,
    output logic [1:0]        pwm_out,
    output logic              cap_irq
);
    typedef struct packed {
        logic [CNT_W-1:0]   cfg;
        logic [PRE_W-1:0]   pre;
        logic [CNT_W-1:0]   per;
        logic [CNT_W-1:0]   duty;
        logic [NUM_CAP-1:0] flags;
    } regs_s;

    regs_s reg_d, reg_q;
    mode_e mode_q;
    logic  mode_chg, tick;
    logic [CNT_W-1:0]   count;
    logic [NUM_CAP-1:0] hits;
    logic [CNT_W-1:0]   cap_val [NUM_CAP];

    assign mode_q   = mode_e'(reg_q.cfg[1:0]);
    assign mode_chg = wr_en && (wr_addr == A_CFG) && (wr_data[1:0] != reg_q.cfg[1:0]);

    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_CFG:   reg_d.cfg  = wr_data;
                A_PRE:   reg_d.pre  = wr_data[PRE_W-1:0];
                A_PER:   reg_d.per  = wr_data;
                A_DUTY:  reg_d.duty = wr_data;
                A_FLAG:  reg_d.flags = reg_q.flags & ~wr_data[NUM_CAP-1:0];
                default: ;
            endcase
        end
        reg_d.flags = reg_d.flags | hits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    mmt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(mode_chg), .limit(reg_q.pre), .tick(tick)
    );

    mmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(mode_chg), .tick(tick), .mode(mode_q),
        .per_cfg(reg_q.per), .duty_cfg(reg_q.duty), .count(count), .pwm(pwm_out)
    );

    for (genvar g = 0; g < NUM_CAP; g++) begin : g_cap
        mmt_capture #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_cap (
            .clk(clk), .rst_n(rst_n), .pin(cap_in[g]), .fall_sel(reg_q.cfg[2+g]),
            .enable(is_capt(mode_q)), .count(count), .hit(hits[g]), .value(cap_val[g])
        );
    end

    always_comb begin
        unique case (rd_addr)
            A_CFG:   rd_data = reg_q.cfg;
            A_PRE:   rd_data = {{(CNT_W-PRE_W){1'b0}}, reg_q.pre};
            A_PER:   rd_data = reg_q.per;
            A_DUTY:  rd_data = reg_q.duty;
            A_CAP0:  rd_data = cap_val[0];
            A_CAP1:  rd_data = cap_val[1];
            A_FLAG:  rd_data = {{(CNT_W-NUM_CAP){1'b0}}, reg_q.flags};
            default: rd_data = count;
        endcase
    end

    assign cap_irq = |reg_q.flags;

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_FLAG) |=> ((reg_q.flags & $past(reg_q.flags)) == $past(reg_q.flags)));

    assert_no_stray_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_capt(mode_q) && !(wr_en && wr_addr == A_FLAG)) |=> (reg_q.flags == $past(reg_q.flags)));

    assert_wide_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_WIDE || is_capt(mode_q)) |-> !pwm_out[1]);

endmodule

// File: tb/sim_mmt_channel.sv
module sim_mmt_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  cap_in = '0;
    logic [1:0]  pwm_out;
    logic        cap_irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    localparam logic [15:0] M_DUAL = 16'd0, M_WIDE = 16'd1, M_CAPT = 16'd2;

    always #10 clk = ~clk;

    mmt_channel u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cap_in(cap_in), .pwm_out(pwm_out),
        .cap_irq(cap_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // leaves the bench at the first sample after the mode-changing write
    task automatic setup(input logic [15:0] mode, input logic [15:0] pre,
                         input logic [15:0] per, input logic [15:0] duty, input logic [15:0] edges);
        wr(3'd0, (mode == M_CAPT) ? M_DUAL : M_CAPT);
        wr(3'd1, pre);
        wr(3'd2, per);
        wr(3'd3, duty);
        wr(3'd0, mode | (edges << 2));
    endtask

    task automatic measure(input int w, output int ha, output int hb);
        ha = 0; hb = 0;
        for (int k = 0; k < w; k++) begin
            ha += int'(pwm_out[0]);
            hb += int'(pwm_out[1]);
            @(negedge clk);
        end
    endtask

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    initial begin
        int v, ha, hb, w, ea, eb, pb, db;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(3'd7, v); check("R1 reset count", v, 0);
        rd(3'd6, v); check("R1 reset flags", v, 0);
        rd(3'd0, v); check("R1 reset cfg", v, 0);
        check("R1 reset pwm", int'(pwm_out), 0);
        check("R9 reset irq", int'(cap_irq), 0);

        // R1: register readback
        wr(3'd1, 16'h005A); rd(3'd1, v); check("R1 divider", v, 16'h5A);
        wr(3'd2, 16'h1234); rd(3'd2, v); check("R1 period", v, 16'h1234);
        wr(3'd3, 16'hBEEF); rd(3'd3, v); check("R1 duty", v, 16'hBEEF);

        // R3/R4/R2: dual 8-bit sweep
        for (int n = 0; n <= 2; n += 2) begin
            for (int pa = 0; pa < 4; pa++) begin
                for (int da = 0; da < 6; da++) begin
                    pb = 6 - pa;
                    db = (da * 3) % 8;
                    setup(M_DUAL, 16'(n), 16'((pb << 8) | pa), 16'((db << 8) | da), 16'd0);
                    w  = (pa + 1) * (pb + 1) * (n + 1) * 2;
                    ea = (w / ((pa + 1) * (n + 1))) * imin(da, pa + 1) * (n + 1);
                    eb = (w / ((pb + 1) * (n + 1))) * imin(db, pb + 1) * (n + 1);
                    measure(w, ha, hb);
                    check("R3 R4 dual low half high clocks", ha, ea);
                    check("R3 R2 dual high half high clocks", hb, eb);
                end
            end
        end

        // R4/R5/R2: wide sweep
        for (int n = 0; n < 2; n++) begin
            for (int pi = 0; pi < 2; pi++) begin
                for (int di = 0; di < 5; di++) begin
                    int p, d;
                    p = (pi == 0) ? 5 : 299;
                    case (di)
                        0: d = 0; 1: d = 4; 2: d = 6; 3: d = 200; default: d = 300;
                    endcase
                    setup(M_WIDE, 16'(n), 16'(p), 16'(d), 16'd0);
                    w = 2 * (p + 1) * (n + 1);
                    measure(w, ha, hb);
                    check("R4 R2 wide high clocks", ha, 2 * imin(d, p + 1) * (n + 1));
                    check("R5 wide second output low", hb, 0);
                end
            end
        end

        // R12: duty written mid-period applies from the next period
        setup(M_WIDE, 16'd0, 16'd9, 16'd6, 16'd0);
        ha = 0;
        for (int i = 0; i < 10; i++) begin
            ha += int'(pwm_out[0]);
            if (i == 3) begin wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'd2; end
            if (i == 4) wr_en = 1'b0;
            @(negedge clk);
        end
        check("R12 current period keeps old duty", ha, 6);
        measure(10, ha, hb);
        check("R12 next period uses new duty", ha, 2);

        // R11: mode change clears counter and divider
        setup(M_WIDE, 16'd3, 16'd9, 16'd0, 16'd0);
        step(7);
        wr(3'd0, M_DUAL);
        rd(3'd7, v); check("R11 count cleared", v, 0);
        step(3); rd(3'd7, v); check("R11 divider restarted, no advance yet", v, 0);
        step(1); rd(3'd7, v); check("R11 first advance after N+1", v, 1);

        // R7/R8/R9: capture, divider 0, ch0 rising, ch1 falling
        setup(M_CAPT, 16'd0, 16'd0, 16'd0, 16'd2);
        step(10); cap_in[0] = 1'b1;             // i = 10
        step(5);  cap_in[1] = 1'b1;             // i = 15, rising on falling channel
        rd(3'd4, v); check("R7 capture value ch0", v, 12);
        rd(3'd6, v); check("R9 flag ch0 set", v, 1);
        check("R9 irq raised", int'(cap_irq), 1);
        step(10);                               // i = 25
        rd(3'd6, v); check("R8 rising edge ignored on falling channel", v, 1);
        cap_in[1] = 1'b0;
        step(5);                                // i = 30
        rd(3'd5, v); check("R8 R7 falling capture ch1", v, 27);
        rd(3'd6, v); check("R9 both flags", v, 3);
        check("R6 pwm low in capture", int'(pwm_out), 0);
        wr(3'd6, 16'd1);
        rd(3'd6, v); check("R9 write-one clears ch0 only", v, 2);
        check("R9 irq still high", int'(cap_irq), 1);
        wr(3'd6, 16'd2);
        rd(3'd6, v); check("R9 all flags cleared", v, 0);
        check("R9 irq low", int'(cap_irq), 0);

        // R7/R2: capture with divider 2
        cap_in[0] = 1'b0;
        setup(M_CAPT, 16'd2, 16'd0, 16'd0, 16'd0);
        step(20); cap_in[0] = 1'b1;             // i = 20
        step(6);
        rd(3'd4, v); check("R7 R2 capture with divider", v, 22 / 3);

        // R6: free-running wrap
        setup(M_CAPT, 16'd0, 16'd0, 16'd0, 16'd0);
        step(65535); rd(3'd7, v); check("R6 count at top", v, 16'hFFFF);
        step(1);     rd(3'd7, v); check("R6 count wrapped", v, 0);

        // R10: edges outside capture mode
        wr(3'd6, 16'd3);
        setup(M_WIDE, 16'd0, 16'd20, 16'd5, 16'd0);
        cap_in = 2'b01; step(5);
        cap_in = 2'b10; step(5);
        cap_in = 2'b01; step(5);
        cap_in = 2'b00; step(5);
        rd(3'd6, v); check("R10 no flag outside capture", v, 0);
        rd(3'd4, v); check("R10 ch0 value kept", v, 22 / 3);
        rd(3'd5, v); check("R10 ch1 value kept", v, 27);
        check("R10 irq low", int'(cap_irq), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule